// File: doc/BRIEF.md
# Run-of-Four Sequence Detector

This block watches a single serial bit and raises its output whenever the last four bits sampled on consecutive rising clock edges all agree. The four may be all ones or all zeros. A longer run keeps the output raised on every further edge, so runs overlap. The output is a Moore output: it comes from the state register alone, so a change of the input between edges never reaches it.

The machine has nine states. Idle (index 0) is the state after reset. Indices 1 to 4 count a run of ones of length 1 to 4, and indices 5 to 8 count a run of zeros of length 1 to 4. The count-4 states hold while the run goes on. An opposite bit moves the machine to count 1 of the other chain, not back to idle. The nine state flip-flops are brought out for observation. A parameter picks the encoding. The plain form is one-hot. The other form inverts bit 0 so that idle is all zeros.

Top module: `run4_detector`

## Requirements
- R1: After the fourth consecutive rising edge that samples `w`=1, `z` is 1 in the cycle that follows that edge.
- R2: After the fourth consecutive rising edge that samples `w`=0, `z` is 1 in the cycle that follows that edge.
- R3: Runs overlap. Every further equal bit after the fourth keeps `z` at 1, and `z` is 0 whenever the last four sampled bits are not all equal.
- R4: A bit opposite to the current run sends the machine to count 1 of the other polarity: index 5 after a run of ones, index 1 after a run of zeros.
- R5: With `ZERO_RESET`=0, `state_q` is one-hot with bit i set for state index i. Idle is 9'h001, ones counts 1..4 are bits 1..4, and zeros counts 1..4 are bits 5..8.
- R6: With `ZERO_RESET`=1, `state_q` is the R5 code with bit 0 inverted. Idle is 9'h000, and every other state has bit 0 set as well as its own bit.
- R7: Reset is synchronous and active low. A rising edge that samples `rst_n`=0 puts the machine in idle with `z`=0. Lowering `rst_n` between edges changes nothing until the next edge.
- R8: `z` depends only on the state. Changing `w` between edges leaves `z` unchanged until the next edge.
- R9: Exactly one state is active at any time. Once bit 0 is undone per R6, `state_q` is one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| w | input | 1 | Serial input bit |
| z | output | 1 | High when the last four sampled bits agree |
| state_q | output | 9 | State flip-flops, encoded per `ZERO_RESET` |

## Verification
A table-driven pass tests each pattern, and each pattern separates a different fault:
- Runs of five ones and then six zeros separate "fires at four" from "fires at three or five" and show that an overlapping run keeps firing.
- A single stray bit between runs, and an isolated 0-1-0 pattern, show that an opposite bit restarts the count at one instead of at idle or at the old count.
- Running both encodings side by side on the same stream ties each state code to its index.
- Directed steps cover a reset in the middle of a run, a reset lowered between edges, and a flip of `w` between edges.

// File: rtl/run4_detector.sv
module run4_detector #(
  parameter bit ZERO_RESET = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       w,
  output logic       z,
  output logic [8:0] state_q
);
  localparam logic [8:0] FLIP     = {8'b0, ZERO_RESET};
  localparam logic [8:0] IDLE_HOT = 9'b0_0000_0001;

  logic [8:0] hot, hot_nx;
  logic       in_ones, in_zeros;

  assign hot      = state_q ^ FLIP;
  assign in_ones  = |hot[4:1];
  assign in_zeros = |hot[8:5];

  always_comb begin
    hot_nx[0] = 1'b0;
    hot_nx[1] =  w & (hot[0] | in_zeros);
    hot_nx[2] =  w & hot[1];
    hot_nx[3] =  w & hot[2];
    hot_nx[4] =  w & (hot[3] | hot[4]);
    hot_nx[5] = !w & (hot[0] | in_ones);
    hot_nx[6] = !w & hot[5];
    hot_nx[7] = !w & hot[6];
    hot_nx[8] = !w & (hot[7] | hot[8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= IDLE_HOT ^ FLIP;
    else        state_q <= hot_nx ^ FLIP;
  end

  assign z = hot[4] | hot[8];
endmodule

// File: rtl/run4_detector_chk.sv
module run4_detector_chk #(
  parameter bit ZERO_RESET = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       w,
  input logic       z,
  input logic [8:0] state_q
);
  localparam logic [8:0] FLIP = {8'b0, ZERO_RESET};

  // R9
  a_r9_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_q ^ FLIP));

  // R7
  a_r7_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (state_q == FLIP ^ 9'h001) && !z);

  // R1 R2 R3: z implies four equal sampled bits
  a_r3_z_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    z |-> ($past(w,1) == $past(w,2)) && ($past(w,2) == $past(w,3))
          && ($past(w,3) == $past(w,4)));

  // R1 R2: four equal bits out of reset raise z
  a_r1_run_gives_z: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n,1) && $past(rst_n,2) && $past(rst_n,3) && $past(rst_n,4)
     && $past(w,1) == $past(w,2) && $past(w,2) == $past(w,3)
     && $past(w,3) == $past(w,4)) |-> z);

  // R4
  a_r4_switch_chain: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(w,1) != $past(w,2) && $past(rst_n,2))
      |-> $countones((state_q ^ FLIP) & 9'b0_0010_0010) == 1);
endmodule

bind run4_detector run4_detector_chk #(.ZERO_RESET(ZERO_RESET)) u_chk (.*);

// File: tb/sim_run4_detector.sv
module sim_run4_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w = 1'b0;
  logic z0, z1;
  logic [8:0] s0, s1;
  int n_chk = 0, n_bad = 0;
  int ones_c = 0, zeros_c = 0;

  always #5 clk = ~clk;

  run4_detector #(.ZERO_RESET(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .w(w), .z(z0), .state_q(s0));
  run4_detector #(.ZERO_RESET(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .w(w), .z(z1), .state_q(s1));

  localparam int N = 20;
  localparam bit W_TAB [N] = '{1,1,1,1,1, 0,0,0,0,0,0, 1, 0, 1,1,1, 0,0,0,0};
  localparam bit Z_TAB [N] = '{0,0,0,1,1, 0,0,0,1,1,1, 0, 0, 0,0,0, 0,0,0,1};

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] code(bit zr);
    int idx;
    idx = (ones_c > 0) ? ones_c : (zeros_c > 0) ? 4 + zeros_c : 0;
    return (9'h001 << idx) ^ {8'b0, zr};
  endfunction

  task automatic model(bit b);
    if (b) begin ones_c = (ones_c < 4) ? ones_c + 1 : 4; zeros_c = 0; end
    else   begin zeros_c = (zeros_c < 4) ? zeros_c + 1 : 4; ones_c = 0; end
  endtask

  task automatic step(bit b);
    w = b;
    @(posedge clk); #1;
    model(b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    ones_c = 0; zeros_c = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(posedge clk); #1;
    do_reset();
    chk("R5 reset code classic", s0, 9'h001);
    chk("R6 reset code zero", s1, 9'h000);
    chk("R7 z after reset", {8'b0, z0 | z1}, 9'h000);

    for (int i = 0; i < N; i++) begin
      step(W_TAB[i]);
      chk(Z_TAB[i] ? (W_TAB[i] ? "R1 z ones" : "R2 z zeros") : "R3 z low", {8'b0, z0}, {8'b0, Z_TAB[i]});
      chk("R3 z zero-enc", {8'b0, z1}, {8'b0, Z_TAB[i]});
      chk("R5 state classic", s0, code(1'b0));
      chk("R6 state zero-enc", s1, code(1'b1));
    end

    // R4: opposite bit after a long run of ones lands on zeros count 1
    do_reset();
    repeat (6) step(1'b1);
    step(1'b0);
    chk("R4 to zeros count 1", s0, 9'h020);
    chk("R4 to zeros count 1 zero-enc", s1, 9'h021);
    step(1'b1);
    chk("R4 to ones count 1", s0, 9'h002);

    // R8: w flipped between edges leaves z unchanged
    do_reset();
    repeat (4) step(1'b1);
    w = 1'b0; #2;
    chk("R8 z held between edges", {8'b0, z0}, 9'h001);
    chk("R8 state held between edges", s0, 9'h010);
    step(1'b0);
    chk("R3 z drops after break", {8'b0, z0}, 9'h000);

    // R7: reset lowered between edges acts only at the edge
    repeat (3) step(1'b0);
    chk("R2 run of zeros", {8'b0, z0}, 9'h001);
    rst_n = 1'b0; #2;
    chk("R7 no change before edge", s0, 9'h100);
    @(posedge clk); #1;
    chk("R7 idle after edge", s0, 9'h001);
    chk("R7 idle zero-enc", s1, 9'h000);
    chk("R7 z low in reset", {8'b0, z0}, 9'h000);
    rst_n = 1'b1; ones_c = 0; zeros_c = 0;

    // R9: alternating bits never raise z, one state each time
    for (int i = 0; i < 8; i++) begin
      step(i[0]);
      chk("R9 alternating classic", s0, code(1'b0));
      chk("R3 alternating z", {8'b0, z0}, 9'h000);
    end

    finish_run();
  end
endmodule